// File: doc/BRIEF.md
# Run-Time Signed/Unsigned Array Multiplier

This block multiplies two 8-bit operands and returns the full 16-bit product with no clock and no storage. One operand acts as the multiplier, the other as the multiplicand. A single control input chooses, at any moment, whether both operands are read as unsigned integers or as two's-complement integers. The same hardware serves both readings.

Each multiplier bit gates the multiplicand into one partial-product row. The rows are summed one after another by full-width ripple-carry adders. For the two's-complement case, the bits whose weight comes from exactly one operand's sign bit are inverted. A fixed correction constant then seeds the accumulation, so no separate negative row or sign-extension field is needed. The product follows any input change after the array settles. A host that wants a held result registers `p_o` itself.

Top module: `arr_mult`

## Requirements
- R1: With `mode_signed_i` = 0, `p_o` equals the unsigned product of `a_i` and `b_i` for every one of the 65536 operand pairs.
- R2: With `mode_signed_i` = 1, `p_o` equals the 16-bit two's-complement encoding of the signed product of `a_i` and `b_i` for every operand pair.
- R3: In unsigned mode, 0xFF times 0xFF gives 0xFE01.
- R4: In signed mode, 0x80 times 0x80 (-128 times -128) gives 0x4000.
- R5: If either operand is zero, `p_o` is zero in both modes.
- R6: When the top bits of both operands are 0, the product is the same in both modes, and its two top bits are 0.
- R7: In signed mode, 0x80 times 0x7F gives 0xC080, and the operand order does not matter.
- R8: `p_o` responds to a change of any input without any clock edge, since the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Multiplier operand |
| b_i | input | 8 | Multiplicand operand |
| mode_signed_i | input | 1 | 1 = both operands two's complement, 0 = both unsigned |
| p_o | output | 16 | Full-width product |

## Verification
The checker reads the operands and the product in the same evaluation. It assumes the inputs are stable long enough for the array to settle before it is sampled. This holds for a zero-delay model and for any bench that drives the inputs and samples after a small delay. The stimulus changes the inputs only just after a falling clock edge and compares 2 ns later, well inside the half period. The assertions check only properties that hold for every operand pair in the mode in force: zero operands, the corner values and sign behaviour. The bench therefore walks the whole operand space in both modes without restriction.

// File: rtl/arr_mult_pkg.sv
package arr_mult_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } mode_e;
endpackage

// File: rtl/arr_mult_pp_row.sv
module arr_mult_pp_row #(
  parameter int unsigned W   = 8,
  parameter int unsigned ROW = 0
) (
  input  logic [W-1:0]   mcand_i,
  input  logic           mplr_bit_i,
  input  logic           mode_signed_i,
  output logic [2*W-1:0] row_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0] bits;

  // bits weighted by exactly one sign bit are inverted in signed mode
  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam bit FLIP = (ROW == W - 1) != (j == W - 1);
    if (FLIP) begin : g_flip
      assign bits[j] = (mplr_bit_i & mcand_i[j]) ^ mode_signed_i;
    end else begin : g_keep
      assign bits[j] = mplr_bit_i & mcand_i[j];
    end
  end

  always_comb begin
    row_o = '0;
    row_o[ROW +: W] = bits;
  end
endmodule

// File: rtl/arr_mult_rca.sv
module arr_mult_rca #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign s_o[k] = x_i[k] ^ y_i[k] ^ c[k];
    if (k < W - 1) begin : g_cy
      assign c[k+1] = (x_i[k] & y_i[k]) | (c[k] & (x_i[k] ^ y_i[k]));
    end
  end
endmodule

// File: rtl/arr_mult.sv
module arr_mult #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           mode_signed_i,
  output logic [2*W-1:0] p_o
);
  import arr_mult_pkg::*;

  localparam int unsigned PW = 2 * W;
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] CORR = (ONE << W) | (ONE << (PW - 1));

  mode_e mode;
  assign mode = mode_e'(mode_signed_i);

  logic [W:0][PW-1:0]   acc;
  logic [W-1:0][PW-1:0] row;

  // correction constant seeds the array in signed mode
  assign acc[0] = (mode == MODE_SGN) ? CORR : '0;

  for (genvar r = 0; r < W; r++) begin : g_row
    arr_mult_pp_row #(.W(W), .ROW(r)) u_pp (
      .mcand_i      (b_i),
      .mplr_bit_i   (a_i[r]),
      .mode_signed_i(mode_signed_i),
      .row_o        (row[r])
    );
    arr_mult_rca #(.W(PW)) u_add (
      .x_i(acc[r]),
      .y_i(row[r]),
      .s_o(acc[r+1])
    );
  end

  assign p_o = acc[W];
endmodule

// File: rtl/arr_mult_chk.sv
module arr_mult_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           mode_signed_i,
  input logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0]  MINV  = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] MAXSQ = {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] MINSQ = PW'(1) << (PW - 2);

  always_comb begin
    a_r5_zero_operand: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
      else $error("zero operand gave nonzero product");
    a_r3_max_unsigned: assert (mode_signed_i || !((a_i == '1) && (b_i == '1)) || (p_o == MAXSQ))
      else $error("unsigned max square wrong");
    a_r4_min_signed: assert (!mode_signed_i || !((a_i == MINV) && (b_i == MINV)) || (p_o == MINSQ))
      else $error("signed min square wrong");
    a_r6_pos_top_clear: assert (a_i[W-1] || b_i[W-1] || (p_o[PW-1:PW-2] == 2'b00))
      else $error("nonnegative operands set top bits");
    a_r1_unit_mult: assert (mode_signed_i || (a_i != W'(1)) || (p_o == {{W{1'b0}}, b_i}))
      else $error("unsigned times one wrong");
    a_r2_signed_sign: assert (!mode_signed_i || (a_i == '0) || (b_i == '0)
                              || (p_o[PW-1] == (a_i[W-1] ^ b_i[W-1])))
      else $error("signed product sign wrong");
  end
endmodule

bind arr_mult arr_mult_chk #(.W(W)) u_chk (
  .a_i          (a_i),
  .b_i          (b_i),
  .mode_signed_i(mode_signed_i),
  .p_o          (p_o)
);

// File: tb/tb_arr_mult.sv
module tb_arr_mult;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic        sgn = 1'b0;
  logic [15:0] p;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  arr_mult dut (.a_i(a), .b_i(b), .mode_signed_i(sgn), .p_o(p));

  function automatic logic [15:0] ref_prod(logic [7:0] x, logic [7:0] y, logic s);
    int ex, ey;
    ex = s ? int'($signed(x)) : int'(x);
    ey = s ? int'($signed(y)) : int'(y);
    return 16'(ex * ey);
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    checks++;
    if (p !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h s=%0d got=%h exp=%h", req, a, b, sgn, p, exp);
    end
  endtask

  task automatic drive(logic [7:0] x, logic [7:0] y, logic s);
    @(negedge clk);
    a = x; b = y; sgn = s;
    #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] tmp;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #2;
    chk("R5 idle zero", 16'h0000);

    drive(8'hFF, 8'hFF, 1'b0); chk("R3", 16'hFE01);
    drive(8'h80, 8'h80, 1'b1); chk("R4", 16'h4000);
    drive(8'h80, 8'h7F, 1'b1); chk("R7", 16'hC080);
    drive(8'h7F, 8'h80, 1'b1); chk("R7 swapped", 16'hC080);
    drive(8'h00, 8'hA5, 1'b1); chk("R5 signed a=0", 16'h0000);
    drive(8'hC3, 8'h00, 1'b0); chk("R5 unsigned b=0", 16'h0000);

    // R6: same nonnegative operands, both modes
    drive(8'h7F, 8'h7F, 1'b0); tmp = p; chk("R6 unsigned", 16'h3F01);
    drive(8'h7F, 8'h7F, 1'b1); chk("R6 signed equals unsigned", tmp);

    // R8: inputs change and product follows inside one low phase
    @(negedge clk);
    a = 8'h03; b = 8'h05; sgn = 1'b0; #1;
    chk("R8 first", 16'h000F);
    sgn = 1'b1; a = 8'hFF; #1;
    chk("R8 mode flip", 16'hFFFB);
    b = 8'hFF; #1;
    chk("R8 operand change", 16'h0001);

    // R1 / R2: exhaustive, both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        for (int j = 0; j < 256; j++) begin
          drive(8'(i), 8'(j), 1'(m));
          chk(m ? "R2" : "R1", ref_prod(8'(i), 8'(j), 1'(m)));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule